// File: doc/BRIEF.md
# I2C Byte Shift Register with Arbitration Detection

This block is the serial data register of an I2C interface. A CPU loads a byte into it in parallel. On each rising SCL edge, signalled by a one-cycle shift strobe, the register moves its contents one place toward the most significant end. The sampled SDA level enters at bit 0, and bit 7 is the value the block presents to SDA. The SDA level is captured on every shift, including while the block is sending. After eight shifts the register therefore holds exactly the byte that appeared on the wire, with the first bit at bit 7.

While transmitting, the block may release SDA and still sample a low level. That means another master has won the bus. The block then raises an arbitration-lost flag and stops driving SDA, but it keeps shifting. The byte that finishes is the byte the winning master sent, so the controller can carry on as a slave receiver without losing data. A bit counter raises a byte-complete flag after the last shift of each byte. A START indication or an accepted load clears the counter.

Top module: `i2c_byte_shifter`

## Requirements
- R1: While reset is held and in the first cycle after it, rd_data is 8'hFF, byte_done and arb_lost are 0, and sda_drive is 1.
- R2: A load request made while the bit count is 0 is accepted. In the next cycle rd_data equals load_data and both byte_done and arb_lost are 0.
- R3: An accepted shift (shift_en high, with neither start_det nor an accepted load in the same cycle) makes the next rd_data equal {rd_data[6:0], sda_in}.
- R4: Eight accepted shifts from count 0 leave rd_data equal to the eight sampled SDA bits. The first bit is at bit 7, and this holds whether or not the block was transmitting.
- R5: byte_done goes to 1 in the cycle after the eighth accepted shift of a byte. It returns to 0 after the next accepted shift, an accepted load or start_det.
- R6: sda_drive equals rd_data[7] when tx_mode is 1 and arb_lost is 0, and is 1 (line released) otherwise. A value of 0 pulls the line low.
- R7: If an accepted shift sees tx_mode 1, arb_lost 0, rd_data[7] 1 and sda_in 0, then arb_lost is 1 in the next cycle. It stays 1 until an accepted load or start_det, and shifting continues meanwhile.
- R8: A load request made while the bit count is between 1 and 7 is ignored. rd_data follows only the shift rule and the byte still completes after the remaining shifts.
- R9: start_det returns the bit count to 0, clears byte_done and arb_lost, and suppresses a shift strobe in the same cycle.
- R10: When an accepted load and shift_en occur in the same cycle, the load wins and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | CPU parallel load request |
| load_data | input | 8 | Byte to load |
| rd_data | output | 8 | Current register contents for CPU read |
| start_det | input | 1 | One-cycle START condition indication |
| shift_en | input | 1 | One-cycle strobe marking a rising SCL edge |
| sda_in | input | 1 | Synchronised SDA level |
| tx_mode | input | 1 | 1 while the block acts as transmitter |
| sda_drive | output | 1 | SDA drive value: 1 releases, 0 pulls low |
| arb_lost | output | 1 | Arbitration-lost flag |
| byte_done | output | 1 | Byte-complete flag |

## Verification
A wrong bit in the shift register appears on rd_data in the cycle after the shift that moved it. It reaches sda_drive within at most seven further shifts, once it has climbed to bit 7. A bit counter that is off by one shows as byte_done rising on the wrong shift, or as a load being accepted or refused wrongly, one cycle after the offending strobe. A wrongly set or missed arbitration flag changes arb_lost and sda_drive on the very next cycle. The bench compares every output at every cycle against a bench-side reference, so each of these faults is reported within the cycle it becomes visible.

// File: rtl/i2c_shift_pkg.sv
package i2c_shift_pkg;
   function automatic int cnt_width(input int bits);
      return (bits <= 2) ? 1 : $clog2(bits);
   endfunction
endpackage

// File: rtl/isr_bit_counter.sv
module isr_bit_counter #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = i2c_shift_pkg::cnt_width(DATA_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             idle,
   output logic             done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic wrap;
   assign wrap = (count == LAST);
   assign idle = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         done  <= 1'b0;
      end else if (clr) begin
         count <= '0;
         done  <= 1'b0;
      end else if (step) begin
         count <= wrap ? '0 : count + 1'b1;
         done  <= wrap;
      end
   end

   a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LAST);
   a_r5_done_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(step) && !$past(clr));
endmodule

// File: rtl/isr_shift_reg.sv
module isr_shift_reg #(
   parameter int          DATA_W    = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              shift,
   input  logic              ser_in,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= RST_VAL;
      else if (load)
         q <= load_val;
      else if (shift)
         q <= {q[DATA_W-2:0], ser_in};
   end

   a_r3_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
      shift && !load |=> q[DATA_W-1:1] == $past(q[DATA_W-2:0]) && q[0] == $past(ser_in));
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(load_val));
endmodule

// File: rtl/isr_arb_detect.sv
module isr_arb_detect #(
   parameter bit ARB_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic shift,
   input  logic tx_mode,
   input  logic own_bit,
   input  logic bus_bit,
   output logic lost
);
   generate
      if (ARB_EN) begin : g_arb
         logic lost_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               lost_q <= 1'b0;
            else if (clr)
               lost_q <= 1'b0;
            else if (shift && tx_mode && own_bit && !bus_bit)
               lost_q <= 1'b1;
         end
         assign lost = lost_q;

         a_r7_lost_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lost) |-> $past(shift) && !$past(bus_bit) && $past(tx_mode));
         a_r7_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            lost && !clr |=> lost);
      end else begin : g_no_arb
         assign lost = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
   parameter int DATA_W = 8,
   parameter bit ARB_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              start_det,
   input  logic              shift_en,
   input  logic              sda_in,
   input  logic              tx_mode,
   output logic              sda_drive,
   output logic              arb_lost,
   output logic              byte_done
);
   localparam int CNT_W = i2c_shift_pkg::cnt_width(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic             idle;
   logic             load_ok;
   logic             shift_ok;
   logic [CNT_W-1:0] count;

   assign load_ok  = load_en && idle;
   assign shift_ok = shift_en && !start_det && !load_ok;

   isr_bit_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(load_ok || start_det), .step(shift_ok),
      .count(count), .idle(idle), .done(byte_done)
   );

   isr_shift_reg #(.DATA_W(DATA_W), .RST_VAL('1)) u_sr (
      .clk(clk), .rst_n(rst_n),
      .load(load_ok), .load_val(load_data),
      .shift(shift_ok), .ser_in(sda_in), .q(rd_data)
   );

   isr_arb_detect #(.ARB_EN(ARB_EN)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .clr(load_ok || start_det), .shift(shift_ok && !arb_lost),
      .tx_mode(tx_mode), .own_bit(rd_data[DATA_W-1]), .bus_bit(sda_in),
      .lost(arb_lost)
   );

   assign sda_drive = rd_data[DATA_W-1] || arb_lost || !tx_mode;

   a_r8_busy_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && !idle && !shift_en && !start_det |=> $stable(rd_data));
   a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !byte_done && !arb_lost && idle);
   a_r6_released_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> sda_drive);
endmodule

// File: tb/i2c_byte_shifter_test.sv
module i2c_byte_shifter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0;
   logic [7:0] load_data = 8'h00;
   logic [7:0] rd_data;
   logic       start_det = 1'b0;
   logic       shift_en = 1'b0;
   logic       sda_in = 1'b1;
   logic       tx_mode = 1'b0;
   logic       sda_drive, arb_lost, byte_done;

   int tests = 0;
   int fails = 0;

   // bench reference state
   logic [7:0] m_reg = 8'hFF;
   int         m_cnt = 0;
   logic       m_done = 1'b0;
   logic       m_lost = 1'b0;

   always #4 clk = ~clk;

   i2c_byte_shifter uut (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
      .rd_data(rd_data), .start_det(start_det), .shift_en(shift_en),
      .sda_in(sda_in), .tx_mode(tx_mode), .sda_drive(sda_drive),
      .arb_lost(arb_lost), .byte_done(byte_done)
   );

   function automatic logic exp_drive(input logic [7:0] r, input logic lost, input logic tx);
      return r[7] || lost || !tx;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      check(rd_data == m_reg, "R3 rd_data", rd_data, m_reg);
      check(byte_done == m_done, "R5 byte_done", byte_done, m_done);
      check(arb_lost == m_lost, "R7 arb_lost", arb_lost, m_lost);
      check(sda_drive == exp_drive(m_reg, m_lost, tx_mode), "R6 sda_drive",
            sda_drive, exp_drive(m_reg, m_lost, tx_mode));
   endtask

   // called at a negative edge; other = level another device puts on SDA
   task automatic step(input logic ld, input logic [7:0] ldd, input logic sh,
                       input logic st, input logic tx, input logic other);
      logic sda, ld_ok, sh_ok;
      sda = exp_drive(m_reg, m_lost, tx) & other;
      load_en = ld; load_data = ldd; shift_en = sh; start_det = st;
      tx_mode = tx; sda_in = sda;
      ld_ok = ld && (m_cnt == 0);
      sh_ok = sh && !st && !ld_ok;
      if (ld_ok || st) begin m_cnt = 0; m_done = 1'b0; m_lost = 1'b0; end
      if (ld_ok) m_reg = ldd;
      if (sh_ok) begin
         if (tx && !m_lost && m_reg[7] && !sda) m_lost = 1'b1;
         m_reg = {m_reg[6:0], sda};
         m_done = (m_cnt == 7);
         m_cnt = (m_cnt == 7) ? 0 : m_cnt + 1;
      end
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic send_byte(input logic tx, input logic [7:0] other);
      for (int i = 7; i >= 0; i--) begin
         step(1'b0, 8'h00, 1'b1, 1'b0, tx, other[i]);
         step(1'b0, 8'h00, 1'b0, 1'b0, tx, 1'b1);
      end
   endtask

   initial begin
      #800000;
      fails++;
      tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h1c2b));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(rd_data == 8'hFF && !byte_done && !arb_lost && sda_drive,
            "R1 reset", {rd_data, byte_done, arb_lost, sda_drive}, {8'hFF, 3'b001});
      rst_n = 1'b1;
      @(negedge clk);
      check(rd_data == 8'hFF && !byte_done && !arb_lost && sda_drive,
            "R1 after reset", {rd_data, byte_done, arb_lost, sda_drive}, {8'hFF, 3'b001});

      // R2 load, R4 transmit with agreeing bus
      step(1'b1, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1);
      check(rd_data == 8'hA5, "R2 load", rd_data, 8'hA5);
      send_byte(1'b1, 8'hFF);
      check(rd_data == 8'hA5 && byte_done, "R4 tx capture", rd_data, 8'hA5);

      // R7 arbitration: own C5, other master sends C1
      step(1'b1, 8'hC5, 1'b0, 1'b0, 1'b1, 1'b1);
      send_byte(1'b1, 8'hC1);
      check(rd_data == 8'hC1 && arb_lost && sda_drive, "R7 lost byte", rd_data, 8'hC1);

      // R4 receive
      step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
      check(!arb_lost, "R2 load clears lost", arb_lost, 0);
      send_byte(1'b0, 8'h3C);
      check(rd_data == 8'h3C && byte_done, "R4 rx capture", rd_data, 8'h3C);

      // R8 load while busy ignored
      step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
      check(rd_data == 8'hFE, "R8 busy load ignored", rd_data, 8'hFE);

      // R9 start clears count and suppresses shift
      step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
      check(rd_data == 8'hFE, "R9 shift suppressed", rd_data, 8'hFE);
      step(1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b1);
      check(rd_data == 8'h5A, "R10 load over shift", rd_data, 8'h5A);

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] r;
         r = 4'($urandom);
         step(r == 0, 8'($urandom), r[3] | r[2], (r == 4'd7), r[1], ($urandom % 4) != 0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule